// File: doc/BRIEF.md
# UART Register Front End

This block is the processor-facing register layer of a serial port. It sits behind an APB-style slave port and exposes a data register, a read-only status word and a read/write control word. Bytes that the line side has already deserialised arrive on a valid/ready byte stream and are held in a deep receive queue. Each processor read of the data register removes the oldest queued byte. Each processor write of the data register hands one byte to the transmit byte stream.

One interrupt line pulses for a single clock for every received byte while the receive-interrupt control bit is set. The prescaler and FIFO-debug registers are placeholders. They read as zero and discard writes. Bit timing, baud generation and line error checks belong to other blocks.

Top module: `uart_reg_frontend`

## Requirements
- R1: Only `paddr_i[7:0]` is decoded. The data register answers at byte offsets 0x00 and 0x03, status at 0x04 and control at 0x08. Any value in the upper address bits gives the same register.
- R2: A write to control (0x08) stores all 32 bits of `pwdata_i`. A read of control returns the stored value. Control resets to zero.
- R3: Status is read-only. A write to 0x04 changes neither status, control nor the receive queue.
- R4: A data-register read returns the oldest queued byte in bits 7:0, with bits 31:8 zero, and removes that byte. Bytes leave the queue in arrival order.
- R5: A data-register read while the queue is empty returns 0 and removes nothing. This also holds when a byte arrives during that access.
- R6: A data-register write puts `pwdata_i[7:0]` on `tx_data_o` with `tx_valid_o` high. Both hold until `tx_ready_i` is seen high. A later write replaces a byte that is still pending.
- R7: `rx_ready_o` is high exactly when fewer than 1024 bytes are queued. An offered byte is queued only when it is accepted.
- R8: Status bit 0 is 1 exactly when the queue is non-empty. It returns to 0 after the read that takes the last byte.
- R9: `irq_o` is high for one clock, in the cycle after each accepted receive byte, when control bit 2 is 1. It stays low when control bit 2 is 0.
- R10: Reads of 0x0C, 0x10 and any unmapped offset (including 0x01 and 0x02) return 0. Writes to those offsets have no effect.
- R11: Status bits 1 and 2 are 1 when no transmit byte is pending and 0 while one is. Bit 8 is 1 when at least 512 bytes are queued. Bit 10 is 1 when 1024 are queued. All other status bits are 0.
- R12: `pready_o` is always 1. Read data is valid in the access phase. A data read removes at most one byte per access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| psel_i | input | 1 | Slave select |
| penable_i | input | 1 | Access phase strobe |
| pwrite_i | input | 1 | 1 = write, 0 = read |
| paddr_i | input | 12 | Byte address; only bits 7:0 are decoded |
| pwdata_i | input | 32 | Write data |
| prdata_o | output | 32 | Read data, registered, valid in access phase |
| pready_o | output | 1 | Always high |
| rx_data_i | input | 8 | Incoming byte |
| rx_valid_i | input | 1 | Incoming byte valid |
| rx_ready_o | output | 1 | Queue has space |
| tx_data_o | output | 8 | Outgoing byte |
| tx_valid_o | output | 1 | Outgoing byte pending |
| tx_ready_i | input | 1 | Consumer takes the outgoing byte |
| irq_o | output | 1 | Receive interrupt pulse |

## Verification
The hardest case to reach is a byte that arrives on the receive stream in the same cycle as the setup phase of a data read on an empty queue. The read must still return zero, and the byte must stay queued for the next read. The bench drives this collision directly by raising the receive valid together with the setup phase. The other case that needs deliberate stimulus is the full-queue boundary. Reaching it takes 1024 accepted bytes, followed by a refused offer and then a full drain in order. Random traffic alone would never get there, so the bench fills the queue explicitly before mixing in random pushes and reads.

// File: rtl/uart_rf_pkg.sv
package uart_rf_pkg;
  localparam logic [7:0] OFS_DATA  = 8'h00;
  localparam logic [7:0] OFS_DATA3 = 8'h03;
  localparam logic [7:0] OFS_STAT  = 8'h04;
  localparam logic [7:0] OFS_CTRL  = 8'h08;

  localparam int ST_DREADY = 0;
  localparam int ST_TSEMPT = 1;
  localparam int ST_TFEMPT = 2;
  localparam int ST_RHALF  = 8;
  localparam int ST_RFULL  = 10;

  localparam int CT_RXIE = 2;

  typedef enum logic [1:0] {
    SEL_DATA,
    SEL_STAT,
    SEL_CTRL,
    SEL_NONE
  } reg_sel_e;
endpackage

// File: rtl/uart_rf_decode.sv
module uart_rf_decode
  import uart_rf_pkg::*;
(
  input  logic [7:0] ofs_i,
  output reg_sel_e   sel_o
);
  always_comb begin
    unique case (ofs_i)
      OFS_DATA, OFS_DATA3: sel_o = SEL_DATA;
      OFS_STAT:            sel_o = SEL_STAT;
      OFS_CTRL:            sel_o = SEL_CTRL;
      default:             sel_o = SEL_NONE;
    endcase
  end
endmodule

// File: rtl/uart_rf_rxq.sv
module uart_rf_rxq #(
  parameter int DEPTH = 1024,
  parameter int W     = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] data_i,
  input  logic         pop_i,
  output logic [W-1:0] head_o,
  output logic         empty_o,
  output logic         full_o,
  output logic         half_o
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count;

  always_ff @(posedge clk_i) begin
    if (push_i) mem[wr_ptr] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_i) wr_ptr <= wr_ptr + 1'b1;
      if (pop_i)  rd_ptr <= rd_ptr + 1'b1;
      case ({push_i, pop_i})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign head_o  = mem[rd_ptr];
  assign empty_o = (count == '0);
  assign full_o  = (count == CW'(DEPTH));
  assign half_o  = (count >= CW'(DEPTH / 2));
endmodule

// File: rtl/uart_rf_txhold.sv
module uart_rf_txhold #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] data_i,
  input  logic         ready_i,
  output logic         valid_o,
  output logic [W-1:0] data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      data_o  <= '0;
    end else if (load_i) begin
      valid_o <= 1'b1;
      data_o  <= data_i;
    end else if (valid_o && ready_i) begin
      valid_o <= 1'b0;
    end
  end
endmodule

// File: rtl/uart_reg_frontend.sv
module uart_reg_frontend
  import uart_rf_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int BYTE_W = 8,
  parameter int DEPTH  = 1024
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              psel_i,
  input  logic              penable_i,
  input  logic              pwrite_i,
  input  logic [ADDR_W-1:0] paddr_i,
  input  logic [DATA_W-1:0] pwdata_i,
  output logic [DATA_W-1:0] prdata_o,
  output logic              pready_o,
  input  logic [BYTE_W-1:0] rx_data_i,
  input  logic              rx_valid_i,
  output logic              rx_ready_o,
  output logic [BYTE_W-1:0] tx_data_o,
  output logic              tx_valid_o,
  input  logic              tx_ready_i,
  output logic              irq_o
);
  reg_sel_e          sel;
  logic              setup, access;
  logic              rd_hit_q, rd_pop, tx_load, rx_push;
  logic              rx_empty, rx_full, rx_half;
  logic [BYTE_W-1:0] rx_head;
  logic [DATA_W-1:0] ctrl_q, status, rd_mux;

  // only the low byte of the address takes part in decoding
  logic unused_addr;
  assign unused_addr = ^paddr_i[ADDR_W-1:8];

  uart_rf_decode u_dec (
    .ofs_i (paddr_i[7:0]),
    .sel_o (sel)
  );

  assign setup   = psel_i && !penable_i;
  assign access  = psel_i && penable_i;
  assign rx_push = rx_valid_i && !rx_full;
  assign rd_pop  = access && !pwrite_i && rd_hit_q;
  assign tx_load = access && pwrite_i && (sel == SEL_DATA);

  uart_rf_rxq #(.DEPTH(DEPTH), .W(BYTE_W)) u_rxq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (rx_push),
    .data_i  (rx_data_i),
    .pop_i   (rd_pop),
    .head_o  (rx_head),
    .empty_o (rx_empty),
    .full_o  (rx_full),
    .half_o  (rx_half)
  );

  uart_rf_txhold #(.W(BYTE_W)) u_tx (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (tx_load),
    .data_i  (pwdata_i[BYTE_W-1:0]),
    .ready_i (tx_ready_i),
    .valid_o (tx_valid_o),
    .data_o  (tx_data_o)
  );

  always_comb begin
    status = '0;
    status[ST_DREADY] = !rx_empty;
    status[ST_TSEMPT] = !tx_valid_o;
    status[ST_TFEMPT] = !tx_valid_o;
    status[ST_RHALF]  = rx_half;
    status[ST_RFULL]  = rx_full;
  end

  always_comb begin
    unique case (sel)
      SEL_DATA: rd_mux = rx_empty ? '0 : DATA_W'(rx_head);
      SEL_STAT: rd_mux = status;
      SEL_CTRL: rd_mux = ctrl_q;
      default:  rd_mux = '0;
    endcase
  end

  // read data and the pop decision are both taken from the setup phase
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prdata_o <= '0;
      rd_hit_q <= 1'b0;
    end else if (setup) begin
      prdata_o <= rd_mux;
      rd_hit_q <= !pwrite_i && (sel == SEL_DATA) && !rx_empty;
    end else if (access) begin
      rd_hit_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      irq_o  <= 1'b0;
    end else begin
      if (access && pwrite_i && (sel == SEL_CTRL)) ctrl_q <= pwdata_i;
      irq_o <= rx_push && ctrl_q[CT_RXIE];
    end
  end

  assign rx_ready_o = !rx_full;
  assign pready_o   = 1'b1;
endmodule

// File: rtl/uart_reg_frontend_chk.sv
module uart_reg_frontend_chk #(
  parameter int BYTE_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              rx_valid_i,
  input logic              rx_ready_o,
  input logic              irq_o,
  input logic              ctrl_rie,
  input logic              tx_valid_o,
  input logic              tx_ready_i,
  input logic [BYTE_W-1:0] tx_data_o,
  input logic              tx_load,
  input logic              rd_pop,
  input logic              rx_empty,
  input logic              pready_o
);
  // R9
  irq_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> $past(rx_valid_i && rx_ready_o && ctrl_rie));

  // R6
  tx_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_valid_o && !tx_ready_i && !tx_load) |=> (tx_valid_o && $stable(tx_data_o)));

  // R8
  push_fills_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_valid_i && rx_ready_o) |=> !rx_empty);

  // R5
  pop_guard_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_pop |-> !rx_empty);

  // R7
  empty_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_empty |-> rx_ready_o);

  // R12
  pready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pready_o);
endmodule

bind uart_reg_frontend uart_reg_frontend_chk #(.BYTE_W(BYTE_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .rx_valid_i (rx_valid_i),
  .rx_ready_o (rx_ready_o),
  .irq_o      (irq_o),
  .ctrl_rie   (ctrl_q[2]),
  .tx_valid_o (tx_valid_o),
  .tx_ready_i (tx_ready_i),
  .tx_data_o  (tx_data_o),
  .tx_load    (tx_load),
  .rd_pop     (rd_pop),
  .rx_empty   (rx_empty),
  .pready_o   (pready_o)
);

// File: tb/uart_reg_frontend_tb.sv
module uart_reg_frontend_tb;
  localparam int CLK_P = 10;
  localparam int DEPTH = 1024;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [11:0] paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic        pready;
  logic [7:0]  rx_data = '0;
  logic        rx_valid = 1'b0;
  logic        rx_ready;
  logic [7:0]  tx_data;
  logic        tx_valid;
  logic        tx_ready = 1'b1;
  logic        irq;

  int vectors = 0;
  int errs = 0;
  logic [7:0]  q[$];
  logic [31:0] ctrl_m = '0;
  logic        txp_m = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  uart_reg_frontend u_dut (
    .clk_i(clk), .rst_ni(rst_n), .psel_i(psel), .penable_i(penable),
    .pwrite_i(pwrite), .paddr_i(paddr), .pwdata_i(pwdata), .prdata_o(prdata),
    .pready_o(pready), .rx_data_i(rx_data), .rx_valid_i(rx_valid),
    .rx_ready_o(rx_ready), .tx_data_o(tx_data), .tx_valid_o(tx_valid),
    .tx_ready_i(tx_ready), .irq_o(irq)
  );

  function automatic logic [31:0] exp_status(int n, logic txp);
    return {21'b0, n == DEPTH, 1'b0, n >= DEPTH/2, 5'b0, ~txp, ~txp, n != 0};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apb_read(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk); psel = 1; penable = 0; pwrite = 0; paddr = a;
    @(negedge clk); penable = 1;
    check("R12 pready", 32'(pready), 32'd1);
    d = prdata;
    @(negedge clk); psel = 0; penable = 0;
  endtask

  task automatic apb_write(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); psel = 1; penable = 0; pwrite = 1; paddr = a; pwdata = d;
    @(negedge clk); penable = 1;
    @(negedge clk); psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic push(input logic [7:0] b);
    logic acc;
    @(negedge clk); rx_valid = 1; rx_data = b;
    acc = (q.size() < DEPTH);
    check("R7 rx_ready", 32'(rx_ready), 32'(acc));
    @(negedge clk); rx_valid = 0;
    check("R9 irq", 32'(irq), 32'(acc && ctrl_m[2]));
    if (acc) q.push_back(b);
  endtask

  task automatic read_data(input logic [11:0] a, input string req);
    logic [31:0] d, e;
    e = (q.size() != 0) ? {24'b0, q[0]} : 32'b0;
    apb_read(a, d);
    check(req, d, e);
    if (q.size() != 0) void'(q.pop_front());
  endtask

  task automatic read_status(input logic [11:0] a, input string req);
    logic [31:0] d;
    apb_read(a, d);
    check(req, d, exp_status(q.size(), txp_m));
  endtask

  initial begin
    #(CLK_P * 150000);
    errs++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
    $finish;
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd1357));
    repeat (3) @(negedge clk);
    rst_n = 1;

    // reset state
    check("R7 reset ready", 32'(rx_ready), 32'd1);
    check("R9 reset irq", 32'(irq), 32'd0);
    check("R6 reset tx", 32'(tx_valid), 32'd0);
    read_status(12'h004, "R11 reset status");
    apb_read(12'h008, d); check("R2 reset ctrl", d, 32'd0);

    // control full-width store, alias through upper address bits
    ctrl_m = 32'h8000_1FFF;
    apb_write(12'h008, ctrl_m);
    apb_read(12'h008, d); check("R2 ctrl readback", d, ctrl_m);
    apb_read(12'hF08, d); check("R1 ctrl alias", d, ctrl_m);
    ctrl_m = 32'h0000_0004;
    apb_write(12'h308, ctrl_m);

    // empty read leaves data-ready clear
    read_data(12'h000, "R5 empty read");
    read_status(12'h004, "R8 empty status");

    // irq pulse is one cycle
    push(8'h11);
    @(negedge clk); check("R9 irq single", 32'(irq), 32'd0);
    push(8'h22);
    read_status(12'h104, "R1 status alias");
    read_data(12'h003, "R1 data at 0x03");
    read_data(12'h000, "R4 data at 0x00");
    read_status(12'h004, "R8 cleared after last");

    // receive byte collides with setup of an empty read
    @(negedge clk); psel = 1; penable = 0; pwrite = 0; paddr = 12'h000;
    rx_valid = 1; rx_data = 8'h5A;
    @(negedge clk); penable = 1; rx_valid = 0;
    check("R5 collide returns zero", prdata, 32'd0);
    @(negedge clk); psel = 0; penable = 0;
    q.push_back(8'h5A);
    read_data(12'h000, "R5 byte kept");

    // read-only status and dead offsets
    apb_write(12'h004, 32'hFFFF_FFFF);
    apb_write(12'h00C, 32'hFFFF_FFFF);
    apb_write(12'h010, 32'hFFFF_FFFF);
    apb_write(12'h001, 32'hFFFF_FFFF);
    read_status(12'h004, "R3 status unchanged");
    apb_read(12'h008, d); check("R3 ctrl unchanged", d, ctrl_m);
    apb_read(12'h00C, d); check("R10 prescaler zero", d, 32'd0);
    apb_read(12'h010, d); check("R10 debug zero", d, 32'd0);
    apb_read(12'h002, d); check("R10 unmapped zero", d, 32'd0);
    apb_read(12'h014, d); check("R10 past window zero", d, 32'd0);
    check("R6 no tx from dead write", 32'(tx_valid), 32'd0);

    // transmit hold and replace
    tx_ready = 0;
    apb_write(12'h000, 32'h0000_01A5); txp_m = 1;
    check("R6 tx valid", 32'(tx_valid), 32'd1);
    check("R6 tx data", 32'(tx_data), 32'hA5);
    read_status(12'h004, "R11 tx pending");
    apb_write(12'h003, 32'hFFFF_FF3C);
    check("R6 tx replaced", 32'(tx_data), 32'h3C);
    @(negedge clk); tx_ready = 1;
    @(negedge clk);
    check("R6 tx taken", 32'(tx_valid), 32'd0);
    txp_m = 0;
    read_status(12'h004, "R11 tx idle");

    // fill to the limit without interrupts
    ctrl_m = 32'h0;
    apb_write(12'h008, ctrl_m);
    for (int i = 0; i < DEPTH; i++) begin
      @(negedge clk); rx_valid = 1; rx_data = 8'(i * 7 + 3);
      @(negedge clk); rx_valid = 0;
      if (irq !== 1'b0) begin errs++; $display("FAIL R9 irq while disabled actual=1 expected=0"); end
      q.push_back(8'(i * 7 + 3));
      if (i == DEPTH/2 - 1) read_status(12'h004, "R11 half");
    end
    read_status(12'h004, "R11 full");
    push(8'hEE);
    check("R7 refused while full", 32'(q.size()), 32'(DEPTH));
    read_data(12'h000, "R4 first out");
    check("R7 space back", 32'(rx_ready), 32'd1);
    while (q.size() > 0) begin
      logic [31:0] e;
      e = {24'b0, q[0]};
      apb_read(12'h000, d);
      void'(q.pop_front());
      vectors++;
      if (d !== e) begin errs++; $display("FAIL R4 drain actual=%h expected=%h", d, e); end
    end
    read_data(12'h000, "R5 drained");
    read_status(12'h004, "R8 drained status");

    // random mix
    ctrl_m = 32'h4;
    apb_write(12'h008, ctrl_m);
    for (int k = 0; k < 600; k++) begin
      case ($urandom % 4)
        0, 1: push(8'($urandom));
        2: read_data(($urandom % 2) ? 12'h003 : 12'h000, "R4 random read");
        default: read_status(12'h004, "R11 random status");
      endcase
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
    $finish;
  end
endmodule